// File: doc/BRIEF.md
# External Interrupt Controller with Grouping

This block collects events from 24 external interrupt pins and presents them to a host interrupt controller on six parent lines. Each pin passes through a two-flop synchroniser. A per-line trigger field then selects one of five detection modes: active-low level, active-high level, rising edge, falling edge or both edges. Detected events are latched into a pending register. Software acknowledges an event by writing a one to its pending bit. A mask register gates pending bits before they reach the parent outputs.

The parent outputs are grouped unevenly. Lines 0 to 3 each drive a parent output of their own. Lines 4 to 7 share one output and lines 8 to 23 share another. Software reads the pending and mask registers to find out which line of a shared group fired. All state is reached through a plain 32-bit register bus that writes in one cycle and reads combinationally.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Under reset every trigger field reads 0, every mask bit reads 1 (mask register reads 0x00FFFFFF), the pending register reads 0 and all parent outputs are low.
- R2: The 4-bit trigger field of line i is at bits [(i mod 8)*4 +: 4] of the register at address 0x88 + (i div 8)*4, and all four bits read back as written. Bits 31:24 of the mask (0xA4) and pending (0xA8) registers read as zero, and any unmapped address reads as zero.
- R3: Trigger decode uses bits [2:0] of the field, and bit 3 has no effect. When bits [2:1] are 00, the line is level-sensitive, active high if bit 0 is 1 and active low if bit 0 is 0. Otherwise bit 1 enables falling-edge detection and bit 2 enables rising-edge detection, and bit 0 is ignored. Codes 0, 1, 2, 4 and 6 therefore give low level, high level, falling, rising and both edges.
- R4: A pin change present at clock edge k is first seen in the pending register after edge k+2.
- R5: Writing to the pending register at 0xA8 clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: The mask register at 0xA4 masks a line when its bit is 1. Pending bits latch events even while masked, and a parent output rises in the cycle after the write that unmasks a pending line.
- R7: Parent outputs 0 to 3 equal the unmasked pending bits of lines 0 to 3. Output 4 is the OR of unmasked pending lines 7:4 and output 5 is the OR of unmasked pending lines 23:8.
- R8: In a level mode the pending bit is set again on every cycle the level stays active, so a clear only holds once the input is inactive.
- R9: A detected event and a write-one-to-clear of the same bit at the same clock edge leave the bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pins_in | input | 24 | Asynchronous external interrupt pins |
| parent_irq | output | 6 | Grouped interrupt outputs to the parent controller |

## Verification
A corrupted pending or mask bit appears on the parent outputs in the same cycle it is stored, so the bench compares all six outputs against a behavioural model on every clock. It also reads back pending and mask contents, which exposes a wrong bit inside a shared group that the OR would hide. A fault in the synchroniser or the edge history shifts pending timing by a cycle, or creates or drops events. The latency checks and the model comparison see this within three clocks of the pin change. A wrong trigger decode shows up as a missing or extra pending bit when a pin is toggled in each mode.

// File: rtl/eic_pkg.sv
// Shared types for the external interrupt controller.
// Assumes a 4-bit trigger field per line, of which bits [2:0] are decoded.
package eic_pkg;

    localparam int TRIG_FIELD_W = 4;

    typedef struct packed {
        logic level_mode;
        logic level_pol;
        logic rise_en;
        logic fall_en;
    } trig_mode_t;

    // Turn a 3-bit trigger code into detection enables.
    function automatic trig_mode_t decode_trig(input logic [2:0] code);
        trig_mode_t m;
        m.level_mode = (code[2:1] == 2'b00);
        m.level_pol  = code[0];
        m.rise_en    = code[2];
        m.fall_en    = code[1];
        return m;
    endfunction

endpackage

// File: rtl/eic_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent (no bus coherency needed); resets to 0.
module eic_sync #(
    parameter int W      = 24,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= din;
            end
        end else begin : g_next
            // Later stages pass the value down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/eic_detect.sv
// Event detector for one synchronised line.
// Holds the previous sample; an edge is a difference between it and the
// current sample. Level modes report an event for every active cycle.
module eic_detect
    import eic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_i,
    input  logic [2:0] code_i,
    output logic       evt_o
);
    logic       prev_q;
    trig_mode_t mode;

    // Remember the last synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    // Produce the event for the selected trigger mode.
    always_comb begin
        mode = decode_trig(code_i);
        if (mode.level_mode)
            evt_o = (level_i == mode.level_pol);
        else
            evt_o = (mode.rise_en &  level_i & ~prev_q) |
                    (mode.fall_en & ~level_i &  prev_q);
    end
endmodule

// File: rtl/eic_group.sv
// Aggregates unmasked pending lines onto parent outputs.
// Lines below DIRECT each get an output; [MID_END-1:DIRECT] share one output,
// [N-1:MID_END] share the last. Assumes DIRECT < MID_END < N.
module eic_group #(
    parameter int N       = 24,
    parameter int DIRECT  = 4,
    parameter int MID_END = 8
) (
    input  logic [N-1:0]      active_i,
    output logic [DIRECT+1:0] parent_o
);
    for (genvar d = 0; d < DIRECT; d++) begin : g_direct
        assign parent_o[d] = active_i[d];
    end

    assign parent_o[DIRECT]   = |active_i[MID_END-1:DIRECT];
    assign parent_o[DIRECT+1] = |active_i[N-1:MID_END];
endmodule

// File: rtl/ext_irq_ctrl.sv
// External interrupt controller top.
// Holds trigger fields, mask and pending registers behind a single-cycle
// write / combinational read bus; synchronises pins, detects events and
// drives grouped parent outputs. Assumes DATA_W is a multiple of the field
// width and the bus master holds bus_addr stable while reading.
module ext_irq_ctrl
    import eic_pkg::*;
#(
    parameter int NUM_LINES    = 24,
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 32,
    parameter int SYNC_STAGES  = 2,
    parameter int DIRECT_LINES = 4,
    parameter int MID_END      = 8,
    parameter int TRIG_BASE    = 'h88,
    parameter int MASK_OFS     = 'ha4,
    parameter int PEND_OFS     = 'ha8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [NUM_LINES-1:0]    pins_in,
    output logic [DIRECT_LINES+1:0] parent_irq
);
    localparam int FIELDS_PER_REG = DATA_W / TRIG_FIELD_W;
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(PEND_OFS);

    logic [TRIG_FIELD_W-1:0] trig_q [NUM_LINES];
    logic [NUM_LINES-1:0]    mask_q;
    logic [NUM_LINES-1:0]    pend_q;
    logic [NUM_LINES-1:0]    line_sync;
    logic [NUM_LINES-1:0]    line_evt;
    logic [NUM_LINES-1:0]    pend_clr;

    // Address of the trigger register that holds a given line.
    function automatic logic [ADDR_W-1:0] trig_addr(input int line);
        return ADDR_W'(TRIG_BASE + (line / FIELDS_PER_REG) * 4);
    endfunction

    // Trigger field storage, written field by field from the bus word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) trig_q[i] <= '0;
        end else if (bus_wr) begin
            for (int i = 0; i < NUM_LINES; i++)
                if (bus_addr == trig_addr(i))
                    trig_q[i] <= bus_wdata[(i % FIELDS_PER_REG) * TRIG_FIELD_W +: TRIG_FIELD_W];
        end
    end

    // Mask register: all lines masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                               mask_q <= '1;
        else if (bus_wr && bus_addr == MASK_ADDR) mask_q <= bus_wdata[NUM_LINES-1:0];
    end

    // Write-one-to-clear strobe for the pending register.
    assign pend_clr = (bus_wr && bus_addr == PEND_ADDR) ? bus_wdata[NUM_LINES-1:0] : '0;

    // Pending latch: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~pend_clr) | line_evt;
    end

    // Combinational read mux over the register map.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == MASK_ADDR) bus_rdata[NUM_LINES-1:0] = mask_q;
        if (bus_addr == PEND_ADDR) bus_rdata[NUM_LINES-1:0] = pend_q;
        for (int i = 0; i < NUM_LINES; i++)
            if (bus_addr == trig_addr(i))
                bus_rdata[(i % FIELDS_PER_REG) * TRIG_FIELD_W +: TRIG_FIELD_W] = trig_q[i];
    end

    eic_sync #(
        .W      (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_in),
        .dout  (line_sync)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        eic_detect u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (line_sync[i]),
            .code_i  (trig_q[i][2:0]),
            .evt_o   (line_evt[i])
        );
    end

    eic_group #(
        .N       (NUM_LINES),
        .DIRECT  (DIRECT_LINES),
        .MID_END (MID_END)
    ) u_group (
        .active_i (pend_q & ~mask_q),
        .parent_o (parent_irq)
    );
endmodule

// File: rtl/eic_checker.sv
// Property checker for ext_irq_ctrl, attached by bind.
// Observes bus, registers, per-line events and parent outputs.
module eic_checker #(
    parameter int N        = 24,
    parameter int P        = 6,
    parameter int ADDR_W   = 8,
    parameter int DW       = 32,
    parameter int MASK_OFS = 'ha4,
    parameter int PEND_OFS = 'ha8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic [N-1:0]      mask_q,
    input logic [N-1:0]      pend_q,
    input logic [N-1:0]      evt,
    input logic [P-1:0]      parent_irq
);
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(PEND_OFS);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mask_q == '1 && pend_q == '0));

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == MASK_ADDR || bus_addr == PEND_ADDR) |-> (bus_rdata[DW-1:N] == '0));

    p_clear_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_addr == PEND_ADDR) |->
            ((pend_q & $past(bus_wdata[N-1:0] & ~evt)) == '0));

    p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> (parent_irq == '0));

    p_event_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((pend_q & $past(evt)) == $past(evt)));
endmodule

bind ext_irq_ctrl eic_checker #(
    .N        (NUM_LINES),
    .P        (DIRECT_LINES + 2),
    .ADDR_W   (ADDR_W),
    .DW       (DATA_W),
    .MASK_OFS (MASK_OFS),
    .PEND_OFS (PEND_OFS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .mask_q     (mask_q),
    .pend_q     (pend_q),
    .evt        (line_evt),
    .parent_irq (parent_irq)
);

// File: tb/ext_irq_ctrl_test.sv
`timescale 1ns/1ps
// Bench for ext_irq_ctrl: behavioural reference model compared every clock,
// plus directed checks with hand-computed expected values.
module ext_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [23:0] pins = 24'h0;
    logic [5:0]  parent_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    ext_irq_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pins_in    (pins),
        .parent_irq (parent_irq)
    );

    always #4 clk = ~clk;

    // Reference model state.
    bit [23:0] m_s1, m_s2, m_prev, m_pend, m_mask, m_ev;
    bit [3:0]  m_trig [24];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0; m_mask = 24'hFFFFFF;
            for (int i = 0; i < 24; i++) m_trig[i] = 4'h0;
        end else begin
            for (int i = 0; i < 24; i++) begin
                if (m_trig[i][2:1] == 2'b00)
                    m_ev[i] = (m_s2[i] == m_trig[i][0]);
                else
                    m_ev[i] = (m_trig[i][2] && m_s2[i] && !m_prev[i]) ||
                              (m_trig[i][1] && !m_s2[i] && m_prev[i]);
            end
            if (bus_wr && bus_addr == 8'hA8) m_pend = m_pend & ~bus_wdata[23:0];
            m_pend = m_pend | m_ev;
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = pins;
            if (bus_wr) begin
                if (bus_addr == 8'hA4) m_mask = bus_wdata[23:0];
                for (int r = 0; r < 3; r++)
                    if (bus_addr == 8'h88 + 8'(4 * r))
                        for (int f = 0; f < 8; f++) m_trig[r*8+f] = bus_wdata[f*4 +: 4];
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] v = 32'h0;
        if (a == 8'hA4) v[23:0] = m_mask;
        if (a == 8'hA8) v[23:0] = m_pend;
        for (int r = 0; r < 3; r++)
            if (a == 8'h88 + 8'(4 * r))
                for (int f = 0; f < 8; f++) v[f*4 +: 4] = m_trig[r*8+f];
        return v;
    endfunction

    function automatic logic [5:0] m_parent();
        logic [23:0] ap = m_pend & ~m_mask;
        return {|ap[23:8], |ap[7:4], ap[3:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // R7: parent outputs against the model on every cycle.
    always @(negedge clk) begin
        if (rst_n && !done) chk("R7 parent", {26'h0, parent_irq}, {26'h0, m_parent()});
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        chk({tag, " model"}, bus_rdata, m_read(a));
    endtask

    task automatic set_pins(input logic [23:0] v);
        @(negedge clk);
        pins = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state.
        idle(2);
        rd("R1 mask", 8'hA4, 32'h00FFFFFF);
        rd("R1 pend", 8'hA8, 32'h0);
        rd("R1 trig0", 8'h88, 32'h0);
        rd("R1 trig2", 8'h90, 32'h0);
        chk("R1 parent", {26'h0, parent_irq}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        idle(3);
        // R3: default low-level mode with low pins sets all pending.
        rd("R3 low level", 8'hA8, 32'h00FFFFFF);
        // R8: clear does not hold while level is active.
        wr(8'hA8, 32'h00FFFFFF);
        rd("R8 level reasserts", 8'hA8, 32'h00FFFFFF);
        // R2: trigger field layout and readback.
        wr(8'h88, 32'hC3591624);
        wr(8'h8C, 32'h44444444);
        wr(8'h90, 32'h66666666);
        rd("R2 trig0", 8'h88, 32'hC3591624);
        rd("R2 trig1", 8'h8C, 32'h44444444);
        rd("R2 trig2", 8'h90, 32'h66666666);
        rd("R2 unmapped", 8'h94, 32'h0);
        rd("R2 unmapped low", 8'h84, 32'h0);
        wr(8'hA8, 32'hFFFFFFFF);
        rd("R5 cleared", 8'hA8, 32'h0);
        wr(8'hA4, 32'hFF000000);
        rd("R6 mask upper", 8'hA4, 32'h0);
        // R4: latency of two edges after sampling.
        set_pins(24'h000001);
        rd("R4 edge k", 8'hA8, 32'h0);
        rd("R4 edge k+1", 8'hA8, 32'h0);
        rd("R4 edge k+2", 8'hA8, 32'h1);
        // R5: write-zero keeps, write-one clears.
        wr(8'hA8, 32'h0);
        rd("R5 zero write", 8'hA8, 32'h1);
        wr(8'hA8, 32'h1);
        rd("R5 one write", 8'hA8, 32'h0);
        // R9: event and clear on the same edge.
        set_pins(24'h000005);
        idle(1);
        wr(8'hA8, 32'h4);
        rd("R9 event kept", 8'hA8, 32'h4);
        wr(8'hA8, 32'h4);
        rd("R9 later clear", 8'hA8, 32'h0);
        // R8: high level on line 3.
        set_pins(24'h00000D);
        idle(4);
        wr(8'hA8, 32'h8);
        rd("R8 high level", 8'hA8, 32'h8);
        set_pins(24'h000005);
        idle(4);
        wr(8'hA8, 32'h8);
        rd("R8 inactive clear", 8'hA8, 32'h0);
        // R3: edge modes and ignored bits.
        set_pins(24'h000007);
        idle(4);
        rd("R3 falling ignores rise", 8'hA8, 32'h0);
        set_pins(24'h000005);
        idle(4);
        rd("R3 falling", 8'hA8, 32'h2);
        wr(8'hA8, 32'hFFFFFF);
        set_pins(24'h0000E5);
        idle(4);
        rd("R3 codes 5 3 C rise", 8'hA8, 32'hA0);
        wr(8'hA8, 32'hFFFFFF);
        set_pins(24'h000005);
        idle(4);
        rd("R3 codes 5 3 C fall", 8'hA8, 32'h40);
        wr(8'hA8, 32'hFFFFFF);
        set_pins(24'h000001);
        idle(4);
        rd("R3 both edges fall", 8'hA8, 32'h4);
        wr(8'hA8, 32'hFFFFFF);
        // R7: grouping.
        set_pins(24'h001001);
        idle(4);
        chk("R7 group high", {26'h0, parent_irq}, 32'h20);
        wr(8'hA8, 32'hFFFFFF);
        set_pins(24'h000011);
        idle(4);
        chk("R7 group mid", {26'h0, parent_irq}, 32'h10);
        set_pins(24'h000001);
        idle(4);
        wr(8'hA8, 32'hFFFFFF);
        // R6: latch while masked, unmask asserts.
        wr(8'hA4, 32'hFFFFFF);
        set_pins(24'h0);
        idle(4);
        wr(8'hA8, 32'hFFFFFF);
        set_pins(24'h000100);
        idle(4);
        rd("R6 latched masked", 8'hA8, 32'h100);
        chk("R6 masked parent", {26'h0, parent_irq}, 32'h0);
        wr(8'hA4, 32'hFFFEFF);
        chk("R6 unmask parent", {26'h0, parent_irq}, 32'h20);
        // Mixed traffic against the model.
        for (int c = 0; c < 400; c++) begin
            int r;
            @(negedge clk);
            pins = 24'($urandom);
            bus_wr = 1'b0;
            r = int'($urandom % 8);
            bus_wdata = $urandom;
            case (r)
                0: begin bus_wr = 1'b1; bus_addr = 8'hA8; end
                1: begin bus_wr = 1'b1; bus_addr = 8'hA4; end
                2: begin bus_wr = 1'b1; bus_addr = 8'h88 + 8'(4 * ($urandom % 3)); end
                default: begin
                    bus_addr = (r == 3) ? 8'hA4 : (r == 4) ? 8'h8C : 8'hA8;
                    #1;
                    chk("R2 R5 R6 model read", bus_rdata, m_read(bus_addr));
                end
            endcase
        end
        @(negedge clk);
        bus_wr = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule